// File: doc/BRIEF.md
# Rate-Matching Receive Elastic Buffer

This block connects two clock domains on a serial receive path. Decoded 9-bit symbols arrive on the recovered clock and leave on the user clock. The two clocks run at nominally the same rate but are never exactly equal. Left alone, a small rate difference would slowly fill or empty the storage. The block prevents this by acting on the correction character, which the far end sends from time to time. When the buffer is running low it plays that character out twice. When the buffer is running high it drops that character. This keeps the fill level close to the midpoint. All other symbols pass through untouched and in order.

The write side decides when to correct. It compares its own pointer with a synchronized copy of the read pointer. A deletion simply skips the write. An insertion is stored once with a repeat tag, and the read side presents that entry twice. After reset, reading stays disabled until the buffer first reaches half full. Real overflow and underflow each latch an error flag that stays set until reset.

Top module: `rx_elastic_buf`

## Requirements
- R1: After reset, `rd_valid`, `cc_ins`, `cc_del`, `err_ovf` and `err_unf` are all 0.
- R2: Until the read side first sees an occupancy of at least 8 entries (half of 16), `rd_en` has no effect and `rd_valid` stays 0.
- R3: Once reading is enabled, `rd_en` with data available makes `rd_valid` 1 after the next `rd_clk` edge. `rd_sym` then carries the next symbol in write order, with bit 8 the K flag and bits 7:0 the data.
- R4: Only the correction character 9'h1BC (K flag 1, data 0xBC) is ever inserted or deleted. Any other symbol, including other K symbols, is stored exactly once.
- R5: A correction character written while the write-side occupancy is 10 or more is not stored. `cc_del` pulses high for one `wr_clk` cycle after that write edge.
- R6: A correction character written while the write-side occupancy is 6 or less is delivered twice in a row on the read side. `cc_ins` pulses high for one `wr_clk` cycle after that write edge.
- R7: A correction character written at an occupancy of 7, 8 or 9 is stored once, and neither flag pulses.
- R8: A write counts as one cycle with `wr_valid` high. If a correction happens on write n, no correction is made before write n+4. A correction character arriving earlier is stored once.
- R9: A write that arrives while 16 entries are held is discarded, and it sets `err_ovf`. `err_ovf` stays set until reset.
- R10: `rd_en` on an empty, read-enabled buffer gives `rd_valid` 0 and sets `err_unf`. `err_unf` stays set until reset.
- R11: Pointers cross between the domains in Gray code through two flip-flop stages. Under a sustained rate mismatch of a few percent in either direction, with periodic correction characters, no error flag is raised. Every non-correction symbol arrives in order, and the number of correction characters read out equals the number written, plus insertions, minus deletions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Symbol present on `wr_sym` this cycle |
| wr_sym | input | 9 | Incoming symbol: K flag in bit 8, data in 7:0 |
| rd_clk | input | 1 | User (read) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Request for one symbol |
| rd_sym | output | 9 | Symbol read out |
| rd_valid | output | 1 | `rd_sym` holds a new symbol this cycle |
| cc_ins | output | 1 | One-cycle pulse (write domain): correction inserted |
| cc_del | output | 1 | One-cycle pulse (write domain): correction deleted |
| err_ovf | output | 1 | Sticky overflow flag (write domain) |
| err_unf | output | 1 | Sticky underflow flag (read domain) |

## Verification
The hardest behaviour to reach is steady closed-loop correction, where the fill level drifts because the two clocks differ and the corrections pull it back. No single directed write can produce that. The bench therefore runs the two clocks at periods about 4% apart: first with the writer faster, then with the reader faster. It streams random symbols with correction characters placed at random intervals, then drains the buffer. At the end it checks symbol order and the balance of correction characters. The exact threshold and spacing boundaries are set up separately with directed sequences. In those, reading is held off so that the write-side occupancy is known exactly when each correction character arrives.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam int SYM_W = 9;
  localparam logic [SYM_W-1:0] CC_SYM = 9'h1BC;

  typedef struct packed {
    logic             dup;
    logic [SYM_W-1:0] sym;
  } eb_entry_t;

  localparam int ENTRY_W = $bits(eb_entry_t);
endpackage

// File: rtl/eb_ram.sv
module eb_ram #(
  parameter int AW = 4,
  parameter int DW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port; holds its value when re is low
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/eb_ptr_sync.sv
module eb_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stg1, stg2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1 <= '0;
      stg2 <= '0;
    end else begin
      stg1 <= gray_in;
      stg2 <= stg1;
    end
  end

  assign bin_out[W-1] = stg2[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_g2b
    assign bin_out[i] = bin_out[i+1] ^ stg2[i];
  end
endmodule

// File: rtl/eb_wr_ctl.sv
module eb_wr_ctl
  import eb_pkg::*;
#(
  parameter int AW      = 4,
  parameter int LO_MARK = 6,
  parameter int HI_MARK = 10,
  parameter int MIN_GAP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [SYM_W-1:0] sym,
  input  logic [AW:0]      rptr_sync,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output eb_entry_t        wdata,
  output logic [AW:0]      wptr_gray,
  output logic             cc_ins,
  output logic             cc_del,
  output logic             err_ovf
);
  localparam int PW    = AW + 1;
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [PW-1:0]    DEPTH_V = PW'(1 << AW);
  localparam logic [PW-1:0]    LO_V    = PW'(LO_MARK);
  localparam logic [PW-1:0]    HI_V    = PW'(HI_MARK);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP - 1);

  logic [PW-1:0]    wptr, wptr_nxt, occ;
  logic [GAP_W-1:0] gap_cnt;
  logic             is_cc, gap_ok, do_del, do_ins, full, ovf_hit;

  assign occ     = wptr - rptr_sync;
  assign is_cc   = (sym == CC_SYM);
  assign gap_ok  = (gap_cnt >= GAP_MAX);
  assign full    = (occ >= DEPTH_V);
  assign do_del  = valid && is_cc && gap_ok && (occ >= HI_V);
  assign do_ins  = valid && is_cc && gap_ok && (occ <= LO_V);
  assign we      = valid && !do_del && !full;
  assign ovf_hit = valid && !do_del && full;

  assign waddr     = wptr[AW-1:0];
  assign wdata.dup = do_ins;
  assign wdata.sym = sym;
  assign wptr_nxt  = wptr + PW'(we);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      wptr_gray <= '0;
      gap_cnt   <= GAP_MAX;
      cc_ins    <= 1'b0;
      cc_del    <= 1'b0;
      err_ovf   <= 1'b0;
    end else begin
      wptr      <= wptr_nxt;
      wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      cc_ins    <= do_ins;
      cc_del    <= do_del;
      if (ovf_hit) err_ovf <= 1'b1;
      if (valid) begin
        if (do_ins || do_del)    gap_cnt <= '0;
        else if (gap_cnt < GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) err_ovf |=> err_ovf);
  // R11
  wr_occ_range_chk: assert property (@(posedge clk) disable iff (rst) occ <= DEPTH_V);
  // R4
  del_src_chk: assert property (@(posedge clk) disable iff (rst)
    cc_del |-> $past(valid && sym == CC_SYM));
  // R8
  corr_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (cc_ins || cc_del) |=> !(cc_ins || cc_del));
endmodule

// File: rtl/eb_rd_ctl.sv
module eb_rd_ctl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   wptr_sync,
  input  logic          q_dup,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rptr_gray,
  output logic          rd_valid,
  output logic          err_unf
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);
  localparam logic [PW-1:0] HALF_V  = PW'(1 << (AW - 1));

  logic [PW-1:0] rptr, rptr_nxt, occ;
  logic          started, fresh, act, rep, do_rep, do_read, unf_hit;

  assign occ     = wptr_sync - rptr;
  assign act     = rd_en && started;
  assign rep     = fresh && q_dup;
  assign do_rep  = act && rep;
  assign do_read = act && !rep && (occ != '0);
  assign unf_hit = act && !rep && (occ == '0);

  assign re       = do_read;
  assign raddr    = rptr[AW-1:0];
  assign rptr_nxt = rptr + PW'(do_read);

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr      <= '0;
      rptr_gray <= '0;
      started   <= 1'b0;
      fresh     <= 1'b0;
      rd_valid  <= 1'b0;
      err_unf   <= 1'b0;
    end else begin
      rptr      <= rptr_nxt;
      rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
      if (occ >= HALF_V) started <= 1'b1;
      rd_valid  <= do_rep || do_read;
      if (do_read)     fresh <= 1'b1;
      else if (do_rep) fresh <= 1'b0;
      if (unf_hit) err_unf <= 1'b1;
    end
  end

  // R10
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst) err_unf |=> err_unf);
  // R2
  holdoff_chk: assert property (@(posedge clk) disable iff (rst) !started |=> !rd_valid);
  // R11
  rd_occ_range_chk: assert property (@(posedge clk) disable iff (rst) occ <= DEPTH_V);
  // R6
  repeat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && started && fresh && q_dup) |=> (rd_valid && $stable(rptr)));
endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
  import eb_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LO_MARK = 6,
  parameter int HI_MARK = 10,
  parameter int MIN_GAP = 4
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             wr_valid,
  input  logic [SYM_W-1:0] wr_sym,
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             rd_en,
  output logic [SYM_W-1:0] rd_sym,
  output logic             rd_valid,
  output logic             cc_ins,
  output logic             cc_del,
  output logic             err_ovf,
  output logic             err_unf
);
  localparam int PW = ADDR_W + 1;

  logic            we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  eb_entry_t       wdata, rdata;
  logic [PW-1:0]   wptr_gray, rptr_gray, wptr_sync, rptr_sync;

  eb_wr_ctl #(
    .AW(ADDR_W), .LO_MARK(LO_MARK), .HI_MARK(HI_MARK), .MIN_GAP(MIN_GAP)
  ) u_wr (
    .clk(wr_clk), .rst(wr_rst), .valid(wr_valid), .sym(wr_sym),
    .rptr_sync(rptr_sync), .we(we), .waddr(waddr), .wdata(wdata),
    .wptr_gray(wptr_gray), .cc_ins(cc_ins), .cc_del(cc_del), .err_ovf(err_ovf)
  );

  eb_ptr_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .gray_in(rptr_gray), .bin_out(rptr_sync)
  );

  eb_ptr_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .gray_in(wptr_gray), .bin_out(wptr_sync)
  );

  eb_ram #(.AW(ADDR_W), .DW(ENTRY_W)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
    .rclk(rd_clk), .rrst(rd_rst), .re(re), .raddr(raddr), .rdata(rdata)
  );

  eb_rd_ctl #(.AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wptr_sync(wptr_sync),
    .q_dup(rdata.dup), .re(re), .raddr(raddr), .rptr_gray(rptr_gray),
    .rd_valid(rd_valid), .err_unf(err_unf)
  );

  assign rd_sym = rdata.sym;
endmodule

// File: tb/tb_rx_elastic_buf.sv
`timescale 1ns/1ps
module tb_rx_elastic_buf;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] CC = 9'h1BC;

  logic wclk = 1'b0, rclk = 1'b0;
  real  rd_half = CLK_PERIOD / 2.0;
  logic wr_rst, rd_rst, wr_valid, rd_en;
  logic [8:0] wr_sym, rd_sym;
  logic rd_valid, cc_ins, cc_del, err_ovf, err_unf;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2.0) wclk = ~wclk;
  always #(rd_half) rclk = ~rclk;

  rx_elastic_buf dut (
    .wr_clk(wclk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_sym(wr_sym),
    .rd_clk(rclk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_sym(rd_sym),
    .rd_valid(rd_valid), .cc_ins(cc_ins), .cc_del(cc_del),
    .err_ovf(err_ovf), .err_unf(err_unf)
  );

  function automatic logic [8:0] dsym(input int i);
    return 9'(8'h20 + i);
  endfunction

  function automatic logic [8:0] rnd_sym();
    logic [8:0] s = 9'($urandom());
    if (s == CC) s = 9'h0BC;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_valid = 1'b0; wr_sym = '0; rd_en = 1'b0;
    wr_rst = 1'b1; rd_rst = 1'b1;
    repeat (4) @(negedge wclk);
    wr_rst = 1'b0;
    @(negedge rclk);
    rd_rst = 1'b0;
    @(negedge wclk);
  endtask

  // drives one write; captures the flags one edge later
  task automatic wr1(input logic [8:0] s, output logic ins, output logic del);
    wr_valid = 1'b1; wr_sym = s;
    @(negedge wclk);
    ins = cc_ins; del = cc_del;
    wr_valid = 1'b0;
  endtask

  task automatic wr_flags(input logic [8:0] s, input logic e_ins, input logic e_del, input string req);
    logic i, d;
    wr1(s, i, d);
    chk(i == e_ins && d == e_del, req, {i, d}, {e_ins, e_del});
  endtask

  task automatic rd1(output logic v, output logic [8:0] s);
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    v = rd_valid; s = rd_sym;
    rd_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [8:0] e, input string req);
    logic v; logic [8:0] s;
    rd1(v, s);
    chk(v && s == e, req, {v, s}, {1'b1, e});
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  // random-phase bookkeeping
  bit mon_on = 1'b0;
  logic [8:0] exp_q [0:4095];
  int n_wr_data, n_rd_data, n_mism, cc_in, cc_out, n_ins, n_del;

  always @(negedge wclk) if (mon_on) begin
    if (cc_ins) n_ins++;
    if (cc_del) n_del++;
  end

  always @(negedge rclk) if (mon_on && rd_valid) begin
    if (rd_sym == CC) cc_out++;
    else begin
      if (n_rd_data >= n_wr_data || exp_q[n_rd_data] != rd_sym) n_mism++;
      n_rd_data++;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic v; logic [8:0] s; logic i, d;
    void'($urandom(32'd2024));

    // ---------- R1 reset state ----------
    do_reset();
    chk(!rd_valid && !cc_ins && !cc_del && !err_ovf && !err_unf, "R1 reset outputs",
        {rd_valid, cc_ins, cc_del, err_ovf, err_unf}, 0);

    // ---------- insertion and spacing (R6, R8, R3) ----------
    wr_flags(CC, 1, 0, "R6 insert at empty");
    wr_flags(CC, 0, 0, "R8 second CC too soon");
    wr_flags(dsym(1), 0, 0, "R4 data write");
    wr_flags(CC, 0, 0, "R8 CC three writes after correction");
    wr_flags(CC, 1, 0, "R8 CC four writes after correction");
    for (int k = 2; k <= 4; k++) wr1(dsym(k), i, d);
    settle();
    rd_expect(CC, "R6 dup first copy");
    rd_expect(CC, "R6 dup second copy");
    rd_expect(CC, "R8 blocked CC once");
    rd_expect(dsym(1), "R3 order");
    rd_expect(CC, "R8 blocked CC once");
    rd_expect(CC, "R6 dup first copy");
    rd_expect(CC, "R6 dup second copy");
    for (int k = 2; k <= 4; k++) rd_expect(dsym(k), "R3 order");

    // ---------- deletion, overflow, underflow (R5, R9, R10) ----------
    do_reset();
    for (int k = 1; k <= 10; k++) wr1(dsym(k), i, d);
    wr_flags(CC, 0, 1, "R5 delete at occupancy 10");
    for (int k = 11; k <= 16; k++) wr1(dsym(k), i, d);
    chk(!err_ovf, "R9 no overflow at 16", err_ovf, 0);
    wr1(dsym(17), i, d);
    chk(err_ovf, "R9 overflow on 17th", err_ovf, 1);
    settle();
    for (int k = 1; k <= 16; k++) rd_expect(dsym(k), "R5 CC removed, R9 extra dropped");
    rd1(v, s);
    chk(!v && err_unf, "R10 underflow", {v, err_unf}, 2'b01);
    repeat (3) @(negedge rclk);
    chk(err_unf && err_ovf, "R9 R10 sticky", {err_ovf, err_unf}, 2'b11);

    // ---------- low boundary and other K symbols (R6, R4) ----------
    do_reset();
    for (int k = 1; k <= 6; k++) wr1(dsym(k), i, d);
    wr_flags(CC, 1, 0, "R6 insert at occupancy 6");
    wr_flags(9'h13C, 0, 0, "R4 other K symbol");
    wr1(dsym(7), i, d);
    settle();
    for (int k = 1; k <= 6; k++) rd_expect(dsym(k), "R3 order");
    rd_expect(CC, "R6 dup first copy");
    rd_expect(CC, "R6 dup second copy");
    rd_expect(9'h13C, "R4 other K once");
    rd_expect(dsym(7), "R4 next after K");

    // ---------- mid band and hold-off (R7, R2) ----------
    do_reset();
    for (int k = 1; k <= 7; k++) wr1(dsym(k), i, d);
    settle();
    rd1(v, s);
    chk(!v, "R2 hold-off at 7 entries", v, 0);
    wr_flags(CC, 0, 0, "R7 no correction at occupancy 7");
    wr1(dsym(8), i, d);
    wr_flags(CC, 0, 0, "R7 no correction at occupancy 9");
    settle();
    for (int k = 1; k <= 7; k++) rd_expect(dsym(k), "R2 R7 order");
    rd_expect(CC, "R7 CC once");
    rd_expect(dsym(8), "R7 order");
    rd_expect(CC, "R7 CC once");

    // ---------- rate mismatch both ways (R11) ----------
    do_reset();
    n_wr_data = 0; n_rd_data = 0; n_mism = 0; cc_in = 0; cc_out = 0; n_ins = 0; n_del = 0;
    mon_on = 1'b1;
    rd_en = 1'b1;
    rd_half = CLK_PERIOD * 0.52;
    begin
      int until_cc = 8;
      for (int n = 0; n < 3000; n++) begin
        if (n == 1500) rd_half = CLK_PERIOD * 0.48;
        wr_valid = 1'b1;
        if (until_cc == 0) begin
          wr_sym = CC; cc_in++;
          until_cc = 6 + int'($urandom_range(9));
        end else begin
          wr_sym = rnd_sym();
          exp_q[n_wr_data] = wr_sym;
          n_wr_data++;
          until_cc--;
        end
        @(negedge wclk);
      end
    end
    wr_valid = 1'b0;
    chk(!err_ovf && !err_unf, "R11 no errors under mismatch", {err_ovf, err_unf}, 0);
    chk(n_ins > 0 && n_del > 0, "R11 both corrections used", {n_ins[15:0], n_del[15:0]}, 1);
    repeat (80) @(negedge rclk);
    mon_on = 1'b0;
    rd_en = 1'b0;
    chk(n_mism == 0 && n_rd_data == n_wr_data, "R11 data order", n_rd_data, n_wr_data);
    chk(cc_out == cc_in + n_ins - n_del, "R11 CC balance", cc_out, cc_in + n_ins - n_del);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule